// File: doc/BRIEF.md
# PCM Time-Slot Port with Signaling-Bit Insertion

This block is the switch-facing serial port of a line-side transceiver. Toward the switch it acts like the serial port of a voice codec. Each frame it shifts out one PCM word that came in from the subscriber line. In the same slot it shifts in one PCM word that will be sent down the line. A frame-sync strobe and a free-running data clock time both directions. Toward the frame sequencer it offers parallel words and signaling bits.

All logic runs on one fast system clock. The data clock and the frame-sync strobe are sampled as ordinary inputs, and the block reacts to the rising and falling edges of the data clock. A frame starts when the strobe is seen high on a rising data-clock edge. After that, exactly one word of bits is used in each direction. Any further clock edges in the frame are ignored, so the data clock may run at any rate.

A mode pin lets one signaling bit share the voice slot. In insert mode, lane 0 of the line-side signaling bits replaces the LSB of the outgoing PCM word. The LSB of the incoming PCM word is taken as lane 0 of the upstream signaling bits, in place of the signaling input pin. The remaining bits carry 7-bit voice. Together with this 8 kbit/s data channel they pass through an ordinary 64 kbit/s time slot.

Top module: `pcm_sig_port`

## Requirements
- R1: After reset, `pcm_oe` is 0, `pcm_out` is 0, `sig_out` is 0, `up_word` is 0, `up_sig` is 0 and `up_valid` is 0.
- R2: A frame starts on a rising `dclk` edge sampled while `fsync` is 1. At that edge `pcm_out` presents bit 7 of the outgoing word. Each later rising edge presents the next lower bit, so the word goes out MSB first.
- R3: `pcm_oe` is 1 from the frame-start edge for exactly 8 rising-edge periods. It goes to 0 on the ninth rising edge. While `pcm_oe` is 0, `pcm_out` is 0.
- R4: `pcm_in` is sampled on the first 8 falling `dclk` edges after frame start and assembled MSB first into `up_word`. All 8 bits are kept, including the LSB. `up_valid` pulses for one system clock as the eighth bit is taken.
- R5: If `ins_mode` is 1 at frame start, the outgoing LSB (bit 0) is `dn_sig[0]` instead of `dn_word[0]`. If `ins_mode` is 0, the outgoing word is `dn_word` unchanged.
- R6: If the frame started with `ins_mode` at 1, `up_sig[0]` is the received PCM LSB and `up_sig[1]` is `sig_in[1]`. Otherwise `up_sig` equals `sig_in`. `up_sig` updates together with `up_valid`.
- R7: `sig_in` is sampled only at the frame-start edge. Later changes within the frame do not affect `up_sig`.
- R8: `sig_out` takes the value of `dn_sig` at the frame-start edge and holds it until the next frame start.
- R9: `ins_mode`, `dn_word` and `dn_sig` are used only as sampled at frame start. Changing them mid-frame alters neither the word being sent nor the extraction rule.
- R10: A frame start that arrives before the slot has finished restarts both directions from bit 7. The unfinished received word is discarded without an `up_valid` pulse.
- R11: `dclk` edges outside a slot produce no `up_valid` pulse and leave `pcm_oe` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than `dclk` |
| rst_n | input | 1 | Asynchronous active-low reset |
| dclk | input | 1 | Switch-side data clock, sampled |
| fsync | input | 1 | Frame-sync strobe, sampled on rising `dclk` |
| pcm_in | input | 1 | Serial PCM from the switch, taken on falling `dclk` |
| pcm_out | output | 1 | Serial PCM to the switch, changes on rising `dclk` |
| pcm_oe | output | 1 | Drive enable for `pcm_out` (high only inside the slot) |
| sig_in | input | 2 | Signaling bits to be sent down the line |
| sig_out | output | 2 | Signaling bits received from the line |
| ins_mode | input | 1 | 1 = carry signaling lane 0 in the PCM LSB |
| dn_word | input | 8 | PCM word from the line, to send to the switch |
| dn_sig | input | 2 | Signaling bits from the line |
| up_word | output | 8 | PCM word received from the switch |
| up_sig | output | 2 | Signaling bits to send down the line |
| up_valid | output | 1 | One-cycle strobe: `up_word`/`up_sig` updated |

## Verification
The bench builds the block with its defaults: an 8-bit word, two signaling lanes, and lane 0 as the inserted lane. It varies the `dclk` half period between one and four system clocks, so both crowded and relaxed edge spacing occur. These values bring the LSB swap, the ninth-edge release of the drive enable, the mid-slot restart and the idle edges between frames within a few hundred cycles. They also cover mid-frame changes to the mode pin and the signaling inputs.

// File: rtl/pcm_sig_pkg.sv
package pcm_sig_pkg;

  // Replace one bit of a word (word widths up to 32 bits).
  function automatic logic [31:0] set_bit(input logic [31:0] w,
                                          input int unsigned idx,
                                          input logic b);
    logic [31:0] r;
    r = w;
    r[idx] = b;
    return r;
  endfunction

  // Word carried in a slot when a signaling bit takes the LSB.
  function automatic logic [31:0] put_lsb(input logic [31:0] w, input logic b);
    return set_bit(w, 0, b);
  endfunction

endpackage

// File: rtl/dclk_edge_det.sv
module dclk_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic dclk,
  output logic rise,
  output logic fall
);
  logic dclk_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dclk_q <= 1'b0;
    else        dclk_q <= dclk;
  end

  assign rise = dclk & ~dclk_q;
  assign fall = ~dclk & dclk_q;
endmodule

// File: rtl/pcm_tx_shifter.sv
module pcm_tx_shifter #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic [WORD_W-1:0] load_word,
  output logic              ser_out,
  output logic              oe
);
  localparam int unsigned CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [WORD_W-1:0] sh;
  logic [CW-1:0]     cnt;
  logic              act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
      act <= 1'b0;
    end else if (start) begin
      sh  <= load_word;
      cnt <= '0;
      act <= 1'b1;
    end else if (step && act) begin
      if (cnt == LAST) begin
        act <= 1'b0;
        sh  <= '0;
      end else begin
        cnt <= cnt + 1'b1;
        sh  <= {sh[WORD_W-2:0], 1'b0};
      end
    end
  end

  assign ser_out = act & sh[WORD_W-1];
  assign oe      = act;
endmodule

// File: rtl/pcm_rx_shifter.sv
module pcm_rx_shifter #(
  parameter int unsigned WORD_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              step,
  input  logic              ser_in,
  output logic              last_bit,
  output logic [WORD_W-1:0] word,
  output logic              done
);
  localparam int unsigned CW = (WORD_W > 1) ? $clog2(WORD_W) : 1;
  localparam logic [CW-1:0] LAST = CW'(WORD_W - 1);

  logic [WORD_W-1:0] sh;
  logic [CW-1:0]     cnt;
  logic              act;

  // Internal event: the final bit of the slot is being taken now.
  assign last_bit = step && act && !start && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh   <= '0;
      cnt  <= '0;
      act  <= 1'b0;
      word <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        cnt <= '0;
        act <= 1'b1;
        sh  <= '0;
      end else if (step && act) begin
        sh <= {sh[WORD_W-2:0], ser_in};
        if (last_bit) begin
          act  <= 1'b0;
          word <= {sh[WORD_W-2:0], ser_in};
          done <= 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/sig_lane_reg.sv
module sig_lane_reg #(
  parameter int unsigned SIG_W    = 2,
  parameter int unsigned INS_LANE = 0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             last_bit,
  input  logic             lsb_in,
  input  logic             ins_mode,
  input  logic [SIG_W-1:0] sig_in,
  input  logic [SIG_W-1:0] dn_sig,
  output logic [SIG_W-1:0] sig_out,
  output logic [SIG_W-1:0] up_sig
);
  import pcm_sig_pkg::*;

  logic [SIG_W-1:0] sig_hold;
  logic             mode_q;
  logic [SIG_W-1:0] merged;

  assign merged = SIG_W'(set_bit(32'(sig_hold), INS_LANE, lsb_in));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_hold <= '0;
      sig_out  <= '0;
      mode_q   <= 1'b0;
      up_sig   <= '0;
    end else begin
      if (start) begin
        sig_hold <= sig_in;
        sig_out  <= dn_sig;
        mode_q   <= ins_mode;
      end
      if (last_bit) up_sig <= mode_q ? merged : sig_hold;
    end
  end
endmodule

// File: rtl/pcm_sig_port.sv
module pcm_sig_port #(
  parameter int unsigned WORD_W   = 8,
  parameter int unsigned SIG_W    = 2,
  parameter int unsigned INS_LANE = 0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dclk,
  input  logic              fsync,
  input  logic              pcm_in,
  output logic              pcm_out,
  output logic              pcm_oe,
  input  logic [SIG_W-1:0]  sig_in,
  output logic [SIG_W-1:0]  sig_out,
  input  logic              ins_mode,
  input  logic [WORD_W-1:0] dn_word,
  input  logic [SIG_W-1:0]  dn_sig,
  output logic [WORD_W-1:0] up_word,
  output logic [SIG_W-1:0]  up_sig,
  output logic              up_valid
);
  import pcm_sig_pkg::*;

  // Named internal events, visible to the bound checker.
  logic              dclk_rise;
  logic              dclk_fall;
  logic              frame_start;
  logic              rx_last_bit;
  logic [WORD_W-1:0] tx_load;

  dclk_edge_det u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .dclk  (dclk),
    .rise  (dclk_rise),
    .fall  (dclk_fall)
  );

  assign frame_start = dclk_rise & fsync;

  assign tx_load = ins_mode ? WORD_W'(put_lsb(32'(dn_word), dn_sig[INS_LANE]))
                            : dn_word;

  pcm_tx_shifter #(.WORD_W(WORD_W)) u_tx (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (frame_start),
    .step      (dclk_rise),
    .load_word (tx_load),
    .ser_out   (pcm_out),
    .oe        (pcm_oe)
  );

  pcm_rx_shifter #(.WORD_W(WORD_W)) u_rx (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (frame_start),
    .step     (dclk_fall),
    .ser_in   (pcm_in),
    .last_bit (rx_last_bit),
    .word     (up_word),
    .done     (up_valid)
  );

  sig_lane_reg #(.SIG_W(SIG_W), .INS_LANE(INS_LANE)) u_sig (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (frame_start),
    .last_bit (rx_last_bit),
    .lsb_in   (pcm_in),
    .ins_mode (ins_mode),
    .sig_in   (sig_in),
    .dn_sig   (dn_sig),
    .sig_out  (sig_out),
    .up_sig   (up_sig)
  );
endmodule

// File: rtl/pcm_sig_port_chk.sv
module pcm_sig_port_chk #(
  parameter int unsigned WORD_W = 8,
  parameter int unsigned SIG_W  = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             dclk_rise,
  input logic             dclk_fall,
  input logic             frame_start,
  input logic             pcm_oe,
  input logic             pcm_out,
  input logic             up_valid,
  input logic [SIG_W-1:0] sig_out
);
  localparam int unsigned KW = $clog2(WORD_W + 2);

  // Rising edges seen while driving since the last frame start.
  logic [KW-1:0] oe_edges;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 oe_edges <= '0;
    else if (frame_start)       oe_edges <= KW'(1);
    else if (dclk_rise && pcm_oe) oe_edges <= oe_edges + 1'b1;
  end

  p_slot_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
    pcm_oe |-> (oe_edges <= KW'(WORD_W)));

  p_idle_low_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !pcm_oe |-> !pcm_out);

  p_start_drives_r2: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> pcm_oe);

  p_bit_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (pcm_oe && !dclk_rise) |=> $stable(pcm_out));

  p_valid_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |=> !up_valid);

  p_valid_after_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    up_valid |-> $past(dclk_fall));

  p_sig_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_start |=> $stable(sig_out));
endmodule

bind pcm_sig_port pcm_sig_port_chk #(.WORD_W(WORD_W), .SIG_W(SIG_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .dclk_rise   (dclk_rise),
  .dclk_fall   (dclk_fall),
  .frame_start (frame_start),
  .pcm_oe      (pcm_oe),
  .pcm_out     (pcm_out),
  .up_valid    (up_valid),
  .sig_out     (sig_out)
);

// File: tb/sim_pcm_sig_port.sv
`timescale 1ns/1ps
module sim_pcm_sig_port;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dclk = 1'b0;
  logic       fsync = 1'b0;
  logic       pcm_in = 1'b0;
  logic       pcm_out, pcm_oe;
  logic [1:0] sig_in = '0;
  logic [1:0] sig_out;
  logic       ins_mode = 1'b0;
  logic [7:0] dn_word = '0;
  logic [1:0] dn_sig = '0;
  logic [7:0] up_word;
  logic [1:0] up_sig;
  logic       up_valid;

  int compared = 0;
  int mismatched = 0;
  int vcnt = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  pcm_sig_port u0 (
    .clk(clk), .rst_n(rst_n), .dclk(dclk), .fsync(fsync), .pcm_in(pcm_in),
    .pcm_out(pcm_out), .pcm_oe(pcm_oe), .sig_in(sig_in), .sig_out(sig_out),
    .ins_mode(ins_mode), .dn_word(dn_word), .dn_sig(dn_sig),
    .up_word(up_word), .up_sig(up_sig), .up_valid(up_valid)
  );

  always @(posedge clk) if (up_valid) vcnt <= vcnt + 1;

  // Expected word sent to the switch.
  function automatic logic [7:0] tx_expect(logic [7:0] w, logic [1:0] s, logic m);
    return m ? {w[7:1], s[0]} : w;
  endfunction

  // Expected upstream signaling bits.
  function automatic logic [1:0] sig_expect(logic [1:0] si, logic [7:0] rx, logic m);
    return m ? {si[1], rx[0]} : si;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic run_frame(input logic [7:0] dw, input logic [1:0] ds,
                           input logic [7:0] iw, input logic [1:0] si,
                           input logic m, input int nbits, input int h);
    int v0;
    logic [7:0] ew;
    v0 = vcnt;
    ew = tx_expect(dw, ds, m);
    for (int i = 0; i < nbits; i++) begin
      @(negedge clk);
      if (i == 0) begin
        dn_word = dw; dn_sig = ds; sig_in = si; ins_mode = m; fsync = 1'b1;
      end
      dclk = 1'b1;
      pcm_in = iw[7-i];
      repeat (h) @(negedge clk);
      check(pcm_oe == 1'b1, "R3 oe in slot", pcm_oe, 1);
      check(pcm_out == ew[7-i], (i == 7) ? "R5 LSB" : "R2 bit", pcm_out, ew[7-i]);
      if (i == 0) check(sig_out == ds, "R8 sig_out", sig_out, ds);
      if (i == 1) begin
        // R7 / R9: disturb every frame-start input mid-frame.
        sig_in = ~si; dn_sig = ~ds; ins_mode = ~m; dn_word = ~dw;
      end
      fsync = 1'b0;
      dclk = 1'b0;
      repeat (h) @(negedge clk);
    end
    if (nbits == 8) begin
      dclk = 1'b1;
      repeat (h) @(negedge clk);
      check(pcm_oe == 1'b0, "R3 release", pcm_oe, 0);
      check(vcnt == v0 + 1, "R4 valid count", vcnt - v0, 1);
      check(up_word == iw, "R4 up_word", up_word, iw);
      check(up_sig == sig_expect(si, iw, m), "R6 R7 R9 up_sig", up_sig,
            sig_expect(si, iw, m));
      check(sig_out == ds, "R8 sig_out held", sig_out, ds);
      dclk = 1'b0;
      repeat (h) @(negedge clk);
    end else begin
      check(vcnt == v0, "R10 no valid on aborted slot", vcnt - v0, 0);
    end
  endtask

  task automatic idle_edges(input int n, input int h);
    int v0;
    v0 = vcnt;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      dclk = 1'b1; pcm_in = 1'($urandom);
      repeat (h) @(negedge clk);
      check(pcm_oe == 1'b0, "R11 oe idle", pcm_oe, 0);
      dclk = 1'b0;
      repeat (h) @(negedge clk);
    end
    check(vcnt == v0, "R11 no valid idle", vcnt - v0, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(pcm_oe == 0 && pcm_out == 0 && sig_out == 0 && up_word == 0 &&
          up_sig == 0 && up_valid == 0, "R1 reset", {pcm_oe, pcm_out, sig_out, up_valid}, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(pcm_oe == 0 && up_word == 0, "R1 after release", pcm_oe, 0);

    // Directed corners.
    run_frame(8'hA5, 2'b10, 8'h3C, 2'b01, 1'b0, 8, 2);
    run_frame(8'hFE, 2'b01, 8'h81, 2'b10, 1'b1, 8, 1);  // R5 insert 1, R6 extract 1
    run_frame(8'h01, 2'b10, 8'h7E, 2'b11, 1'b1, 8, 3);  // R5 insert 0, R6 extract 0
    idle_edges(5, 2);
    run_frame(8'hC3, 2'b11, 8'h55, 2'b00, 1'b0, 3, 2);  // R10 abort after 3 bits
    run_frame(8'h96, 2'b00, 8'hE7, 2'b10, 1'b1, 8, 2);  // R10 restart completes

    // Random frames.
    for (int k = 0; k < 40; k++) begin
      int nb;
      nb = ($urandom % 5 == 0) ? 1 + ($urandom % 7) : 8;
      run_frame(8'($urandom), 2'($urandom), 8'($urandom), 2'($urandom),
                1'($urandom), nb, 1 + ($urandom % 4));
      if (nb == 8 && ($urandom % 3 == 0)) idle_edges(1 + ($urandom % 3), 1 + ($urandom % 4));
    end
    run_frame(8'h5A, 2'b01, 8'h99, 2'b01, 1'b0, 8, 1);

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule